// File: doc/BRIEF.md
# System Clock Mode Supervisor

This block chooses where the system clock comes from and keeps watch over the clocks around a frequency-synthesis loop. It runs on its own always-on supervisor clock. It observes two clocks: the reference clock, and the synthesized clock that the loop produces. It also observes the loop's lock indication. It drives three controls: the power request for the loop, the select for an external glitch-free clock mux, and the setting of a reduced-frequency post-divider.

Software chooses one of three modes: loop powered down with the reference clock selected, loop running with the reference clock still selected, or normal operation on the synthesized clock. The block tracks lock continuously. It also measures each clock by counting its rising edges over a fixed window of supervisor-clock cycles and comparing the count with a programmable range.

Each fault source sets a sticky flag, which software clears by writing one. Per source, software chooses whether the flag requests an interrupt or a system reset. A bad synthesized clock can instead make the block fall back to the reference clock. The block stays on the reference clock until software writes the mode again.

Top module: `clk_mode_supervisor`

## Requirements
- R1: After reset, mode_o is 01 (loop running, reference clock selected), loop_pwr_o is 1, sel_syn_o is 0, flags_o is 000, irq_o and rst_req_o are 0, and post_div_o equals the DIV_RST parameter.
- R2: A pulse on mode_wr_i loads mode_req_i into mode_o on the next cycle. Codes: 00 loop off (loop_pwr_o 0), 01 bypass with loop running (loop_pwr_o 1), 10 normal (loop_pwr_o 1). A write of code 11 is ignored and mode_o keeps its value.
- R3: sel_syn_o is 1 only while mode_o is 10 and no fallback is active. In modes 00 and 01 it is 0.
- R4: flags_o[0] (lock loss) sets about three cycles after lock_i falls, provided lock_i had been seen high while the loop was powered. The flag does not set if lock was never seen since power-up, or while the loop is off. One loss sets the flag once, and lock must be seen again before another loss can set it.
- R5: The lock-loss response is chosen by lol_rst_en_i: 1 gives a reset request, 0 gives an interrupt if lol_ie_i is 1.
- R6: Each flag in flags_o stays set until its bit of flag_clr_i is pulsed (write-one-to-clear). A set event in the same cycle as a clear wins.
- R7: irq_o is the OR over sources of flag AND interrupt-enable AND NOT reset-enable. rst_req_o is the OR over sources of flag AND reset-enable, and the interrupt enables do not gate it.
- R8: The number of ref_clk_i rising edges in each window of WIN supervisor cycles is compared with [ref_min_i, ref_max_i]. A count outside the range, including a stopped clock, sets flags_o[1].
- R9: The syn_clk_i edge count is checked against [syn_min_i, syn_max_i] only while the loop is powered and lock is high. A count outside the range then sets flags_o[2].
- R10: A synthesized-clock fault with syn_rst_en_i at 0 while mode_o is 10 drops sel_syn_o to 0 (fallback) and leaves mode_o at 10. sel_syn_o stays 0 even after the fault goes away. With syn_rst_en_i at 1 there is no fallback, and a reset is requested instead.
- R11: A valid mode write clears the fallback, so writing 10 reselects the synthesized clock.
- R12: A pulse on div_wr_i loads div_req_i into post_div_o on the next cycle, and post_div_o is otherwise held. A divider write leaves loop_pwr_o, sel_syn_o and flags_o unchanged, so the loop does not have to regain lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on supervisor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock under measurement |
| syn_clk_i | input | 1 | Synthesized clock under measurement |
| lock_i | input | 1 | Lock indication from the loop (asynchronous) |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_req_i | input | 2 | Requested mode code |
| div_wr_i | input | 1 | Post-divider write strobe |
| div_req_i | input | DIV_W | Requested post-divider setting |
| lol_rst_en_i | input | 1 | Lock loss requests reset instead of interrupt |
| ref_rst_en_i | input | 1 | Reference fault requests reset instead of interrupt |
| syn_rst_en_i | input | 1 | Synthesized fault requests reset instead of fallback |
| lol_ie_i | input | 1 | Lock-loss interrupt enable |
| ref_ie_i | input | 1 | Reference-fault interrupt enable |
| syn_ie_i | input | 1 | Synthesized-fault interrupt enable |
| flag_clr_i | input | 3 | Write-one-to-clear strobes for the flags |
| ref_min_i | input | CNT_W | Lowest good reference edge count per window |
| ref_max_i | input | CNT_W | Highest good reference edge count per window |
| syn_min_i | input | CNT_W | Lowest good synthesized edge count per window |
| syn_max_i | input | CNT_W | Highest good synthesized edge count per window |
| loop_pwr_o | output | 1 | Loop power request |
| sel_syn_o | output | 1 | Clock mux select, 1 selects the synthesized clock |
| post_div_o | output | DIV_W | Post-divider setting |
| mode_o | output | 2 | Current mode code |
| flags_o | output | 3 | Sticky flags: [0] lock loss, [1] reference fault, [2] synthesized fault |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |

## Verification
The assertions take mode_wr_i, div_wr_i and flag_clr_i to be single-cycle strobes that are synchronous to the supervisor clock. They take the range limits to change only between measurements, and the two measured clocks to be free of glitches that the gray-coded crossing could not absorb. The stimulus drives every strobe and configuration input on the falling supervisor edge, for exactly one cycle. It changes range limits, and starts or stops a measured clock, only some windows before it samples a result. Every check is made at least three windows after the last change, so a window that straddles the change cannot decide the outcome.

// File: rtl/clksup_pkg.sv
`timescale 1ns/1ps
package clksup_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_BYP  = 2'b01,
    MODE_NORM = 2'b10
  } mode_e;

  localparam int NFLG    = 3;
  localparam int FLG_LOL = 0;
  localparam int FLG_REF = 1;
  localparam int FLG_SYN = 2;

  // mode code 11 carries no mode and is dropped on write
  function automatic logic mode_code_ok(input logic [1:0] code);
    return code != 2'b11;
  endfunction

  // interrupt: flagged sources that are enabled and not routed to reset
  function automatic logic irq_of(input logic [NFLG-1:0] flg,
                                  input logic [NFLG-1:0] ie,
                                  input logic [NFLG-1:0] rst_en);
    return |(flg & ie & ~rst_en);
  endfunction

  // reset request: flagged sources routed to reset, not gated by enables
  function automatic logic rst_of(input logic [NFLG-1:0] flg,
                                  input logic [NFLG-1:0] rst_en);
    return |(flg & rst_en);
  endfunction

endpackage

// File: rtl/clksup_window_timer.sv
`timescale 1ns/1ps
module clksup_window_timer #(
  parameter int WIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign stb_o = (cnt_q == LAST);
endmodule

// File: rtl/clksup_edge_meter.sv
`timescale 1ns/1ps
module clksup_edge_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_clk_i,
  input  logic             sample_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic logic out_of_range(input logic [CNT_W-1:0] d,
                                        input logic [CNT_W-1:0] lo,
                                        input logic [CNT_W-1:0] hi);
    return (d < lo) || (d > hi);
  endfunction

  // counter in the measured domain, kept in gray code for the crossing
  logic [CNT_W-1:0] gray_q;
  always_ff @(posedge meas_clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin2gray(gray2bin(gray_q) + ONE);
  end

  // two-stage crossing into the supervisor domain
  logic [CNT_W-1:0] sy1_q, sy2_q, last_q;
  logic [CNT_W-1:0] cur_bin, delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= gray_q;
      sy2_q <= sy1_q;
    end
  end

  assign cur_bin = gray2bin(sy2_q);
  assign delta   = cur_bin - last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      fault_o <= 1'b0;
    end else if (sample_i) begin
      last_q  <= cur_bin;
      fault_o <= out_of_range(delta, lo_i, hi_i);
    end else begin
      fault_o <= 1'b0;
    end
  end
endmodule

// File: rtl/clksup_mode_ctrl.sv
`timescale 1ns/1ps
module clksup_mode_ctrl
  import clksup_pkg::*;
#(
  parameter int               DIV_W   = 3,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_req_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_req_i,
  input  logic             syn_fault_i,
  input  logic             syn_rst_en_i,
  output logic [1:0]       mode_o,
  output logic             fb_o,
  output logic             loop_pwr_o,
  output logic             sel_syn_o,
  output logic [DIV_W-1:0] post_div_o
);
  mode_e            mode_q;
  logic             fb_q;
  logic [DIV_W-1:0] div_q;
  logic             mode_take;
  logic             fb_set;

  assign mode_take = mode_wr_i && mode_code_ok(mode_req_i);
  assign fb_set    = syn_fault_i && !syn_rst_en_i && (mode_q == MODE_NORM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BYP;
      fb_q   <= 1'b0;
    end else if (mode_take) begin
      mode_q <= mode_e'(mode_req_i);
      fb_q   <= 1'b0;
    end else if (fb_set) begin
      fb_q   <= 1'b1;
    end
  end

  // divider path is independent of mode and lock state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= DIV_RST;
    else if (div_wr_i) div_q <= div_req_i;
  end

  assign mode_o     = mode_q;
  assign fb_o       = fb_q;
  assign loop_pwr_o = (mode_q != MODE_OFF);
  assign sel_syn_o  = (mode_q == MODE_NORM) && !fb_q;
  assign post_div_o = div_q;
endmodule

// File: rtl/clksup_event_flags.sv
`timescale 1ns/1ps
module clksup_event_flags
  import clksup_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic            loop_pwr_i,
  input  logic            ref_fault_i,
  input  logic            syn_fault_i,
  input  logic [NFLG-1:0] clr_i,
  input  logic [NFLG-1:0] ie_i,
  input  logic [NFLG-1:0] rst_en_i,
  output logic            lock_s_o,
  output logic            lol_evt_o,
  output logic [NFLG-1:0] flags_o,
  output logic            irq_o,
  output logic            rst_req_o
);
  logic            lk1_q, lk2_q, seen_q;
  logic [NFLG-1:0] flg_q, set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk1_q <= 1'b0;
      lk2_q <= 1'b0;
    end else begin
      lk1_q <= lock_i;
      lk2_q <= lk1_q;
    end
  end

  assign lock_s_o  = lk2_q;
  assign lol_evt_o = seen_q && !lk2_q && loop_pwr_i;

  // arm on lock, disarm on loss or power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (!loop_pwr_i) seen_q <= 1'b0;
    else if (lol_evt_o)   seen_q <= 1'b0;
    else if (lk2_q)       seen_q <= 1'b1;
  end

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_LOL] = lol_evt_o;
    set_vec[FLG_REF] = ref_fault_i;
    set_vec[FLG_SYN] = syn_fault_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_i) | set_vec;
  end

  assign flags_o   = flg_q;
  assign irq_o     = irq_of(flg_q, ie_i, rst_en_i);
  assign rst_req_o = rst_of(flg_q, rst_en_i);
endmodule

// File: rtl/clk_mode_supervisor.sv
`timescale 1ns/1ps
module clk_mode_supervisor
  import clksup_pkg::*;
#(
  parameter int               WIN     = 64,
  parameter int               CNT_W   = 8,
  parameter int               DIV_W   = 3,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             syn_clk_i,
  input  logic             lock_i,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_req_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_req_i,
  input  logic             lol_rst_en_i,
  input  logic             ref_rst_en_i,
  input  logic             syn_rst_en_i,
  input  logic             lol_ie_i,
  input  logic             ref_ie_i,
  input  logic             syn_ie_i,
  input  logic [2:0]       flag_clr_i,
  input  logic [CNT_W-1:0] ref_min_i,
  input  logic [CNT_W-1:0] ref_max_i,
  input  logic [CNT_W-1:0] syn_min_i,
  input  logic [CNT_W-1:0] syn_max_i,
  output logic             loop_pwr_o,
  output logic             sel_syn_o,
  output logic [DIV_W-1:0] post_div_o,
  output logic [1:0]       mode_o,
  output logic [2:0]       flags_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int NMEAS = 2;  // index 0: reference, 1: synthesized

  // named internal events, visible to the bound checker
  logic            win_stb;
  logic            lock_s;
  logic            lol_evt;
  logic            ref_evt;
  logic            syn_evt;
  logic            fb_active;
  logic [NFLG-1:0] ie_vec, rst_vec;

  logic [NMEAS-1:0] meas_clk, meas_fault;
  logic [CNT_W-1:0] lo_a [NMEAS];
  logic [CNT_W-1:0] hi_a [NMEAS];

  assign meas_clk = {syn_clk_i, ref_clk_i};
  assign lo_a[0]  = ref_min_i;
  assign hi_a[0]  = ref_max_i;
  assign lo_a[1]  = syn_min_i;
  assign hi_a[1]  = syn_max_i;

  clksup_window_timer #(.WIN(WIN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_o  (win_stb)
  );

  for (genvar g = 0; g < NMEAS; g++) begin : g_meter
    clksup_edge_meter #(.CNT_W(CNT_W)) u_meter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .meas_clk_i (meas_clk[g]),
      .sample_i   (win_stb),
      .lo_i       (lo_a[g]),
      .hi_i       (hi_a[g]),
      .fault_o    (meas_fault[g])
    );
  end

  assign ref_evt = meas_fault[0];
  assign syn_evt = meas_fault[1] && loop_pwr_o && lock_s;

  assign ie_vec  = {syn_ie_i, ref_ie_i, lol_ie_i};
  assign rst_vec = {syn_rst_en_i, ref_rst_en_i, lol_rst_en_i};

  clksup_mode_ctrl #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (mode_wr_i),
    .mode_req_i   (mode_req_i),
    .div_wr_i     (div_wr_i),
    .div_req_i    (div_req_i),
    .syn_fault_i  (syn_evt),
    .syn_rst_en_i (syn_rst_en_i),
    .mode_o       (mode_o),
    .fb_o         (fb_active),
    .loop_pwr_o   (loop_pwr_o),
    .sel_syn_o    (sel_syn_o),
    .post_div_o   (post_div_o)
  );

  clksup_event_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (lock_i),
    .loop_pwr_i  (loop_pwr_o),
    .ref_fault_i (ref_evt),
    .syn_fault_i (syn_evt),
    .clr_i       (flag_clr_i),
    .ie_i        (ie_vec),
    .rst_en_i    (rst_vec),
    .lock_s_o    (lock_s),
    .lol_evt_o   (lol_evt),
    .flags_o     (flags_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
  );
endmodule

// File: rtl/clksup_checker.sv
`timescale 1ns/1ps
module clksup_checker #(
  parameter int DIV_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_wr_i,
  input logic             div_wr_i,
  input logic [DIV_W-1:0] div_req_i,
  input logic [2:0]       flag_clr_i,
  input logic [2:0]       ie_vec,
  input logic [2:0]       rst_vec,
  input logic             syn_rst_en_i,
  input logic [1:0]       mode_o,
  input logic             sel_syn_o,
  input logic             loop_pwr_o,
  input logic [DIV_W-1:0] post_div_o,
  input logic [2:0]       flags_o,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             lock_s,
  input logic             lol_evt,
  input logic             ref_evt,
  input logic             syn_evt,
  input logic             fb_active
);
  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  p_sel_norm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_syn_o |-> (mode_o == 2'b10));

  p_lol_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_evt |=> flags_o[0]);

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i)));

  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(flags_o & ie_vec & ~rst_vec));

  p_rst_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> |(flags_o & rst_vec));

  p_ref_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_evt |=> flags_o[1]);

  p_syn_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_evt |=> flags_o[2]);

  p_syn_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flags_o[2]) && !$past(flag_clr_i[2])) |-> $past(lock_s));

  p_fallback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_evt && !syn_rst_en_i && mode_o == 2'b10 && !mode_wr_i) |=> (!sel_syn_o && fb_active));

  p_fallback_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_active && !mode_wr_i) |=> !sel_syn_o);

  p_div_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_wr_i |=> $stable(post_div_o));

  p_div_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr_i |=> (post_div_o == $past(div_req_i)));

  p_div_keeps_pwr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_wr_i && !mode_wr_i) |=> $stable(loop_pwr_o));
endmodule

bind clk_mode_supervisor clksup_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_wr_i    (mode_wr_i),
  .div_wr_i     (div_wr_i),
  .div_req_i    (div_req_i),
  .flag_clr_i   (flag_clr_i),
  .ie_vec       (ie_vec),
  .rst_vec      (rst_vec),
  .syn_rst_en_i (syn_rst_en_i),
  .mode_o       (mode_o),
  .sel_syn_o    (sel_syn_o),
  .loop_pwr_o   (loop_pwr_o),
  .post_div_o   (post_div_o),
  .flags_o      (flags_o),
  .irq_o        (irq_o),
  .rst_req_o    (rst_req_o),
  .lock_s       (lock_s),
  .lol_evt      (lol_evt),
  .ref_evt      (ref_evt),
  .syn_evt      (syn_evt),
  .fb_active    (fb_active)
);

// File: tb/tb_clk_mode_supervisor.sv
`timescale 1ns/1ps
module tb_clk_mode_supervisor;
  localparam int WIN   = 64;
  localparam int CNT_W = 8;
  localparam int DIV_W = 3;
  localparam int WAITW = 3 * WIN + 10;

  logic clk = 0, rst_n = 0;
  logic ref_clk = 0, syn_clk = 0, ref_run = 1, syn_run = 1;
  logic lock = 0, mode_wr = 0, div_wr = 0;
  logic [1:0] mode_req = 0;
  logic [DIV_W-1:0] div_req = 0;
  logic lol_rst_en = 0, ref_rst_en = 0, syn_rst_en = 0;
  logic lol_ie = 1, ref_ie = 1, syn_ie = 1;
  logic [2:0] flag_clr = 0;
  // reference: period 40 ns -> 16 edges per 640 ns window
  // synthesized: period 8 ns -> 80 edges per window
  logic [CNT_W-1:0] ref_min = 12, ref_max = 20, syn_min = 74, syn_max = 86;

  logic loop_pwr, sel_syn, irq, rst_req;
  logic [DIV_W-1:0] post_div;
  logic [1:0] mode;
  logic [2:0] flags;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always #20 if (ref_run) ref_clk = ~ref_clk;
  always #4  if (syn_run) syn_clk = ~syn_clk;

  clk_mode_supervisor #(.WIN(WIN), .CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RST(3'd0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .syn_clk_i(syn_clk),
    .lock_i(lock), .mode_wr_i(mode_wr), .mode_req_i(mode_req),
    .div_wr_i(div_wr), .div_req_i(div_req),
    .lol_rst_en_i(lol_rst_en), .ref_rst_en_i(ref_rst_en), .syn_rst_en_i(syn_rst_en),
    .lol_ie_i(lol_ie), .ref_ie_i(ref_ie), .syn_ie_i(syn_ie),
    .flag_clr_i(flag_clr),
    .ref_min_i(ref_min), .ref_max_i(ref_max), .syn_min_i(syn_min), .syn_max_i(syn_max),
    .loop_pwr_o(loop_pwr), .sel_syn_o(sel_syn), .post_div_o(post_div),
    .mode_o(mode), .flags_o(flags), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_req = m; mode_wr = 1; tick(1); mode_wr = 0;
  endtask

  task automatic clear_flags(input logic [2:0] c);
    flag_clr = c; tick(1); flag_clr = 0;
  endtask

  task automatic write_div(input logic [DIV_W-1:0] d);
    div_req = d; div_wr = 1; tick(1); div_wr = 0;
  endtask

  // expected mode outputs computed from the mode code
  function automatic int exp_pwr(input int m); return (m == 0) ? 0 : 1; endfunction
  function automatic int exp_sel(input int m); return (m == 2) ? 1 : 0; endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cur;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 mode", mode, 1);
    chk("R1 loop_pwr", loop_pwr, 1);
    chk("R1 sel_syn", sel_syn, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 post_div", post_div, 0);

    // R8 in-range reference, R9 synthesized not judged without lock
    tick(WAITW);
    chk("R8 no fault in range", flags, 0);

    // R2/R3 sweep of every mode code
    cur = 1;
    for (int m = 0; m < 4; m++) begin
      write_mode(m[1:0]);
      if (m != 3) cur = m;
      chk("R2 mode code", mode, cur);
      chk("R2 loop_pwr", loop_pwr, exp_pwr(cur));
      chk("R3 sel_syn", sel_syn, exp_sel(cur));
    end
    write_mode(2'b01);
    chk("R2 back to bypass", mode, 1);

    // R4 lock loss after lock
    lock = 1; tick(6);
    chk("R4 no flag while locked", flags[0], 0);
    lock = 0; tick(6);
    chk("R4 loss after lock", flags[0], 1);
    // R5/R7 sweep of enable and routing for the lock-loss source
    for (int c = 0; c < 4; c++) begin
      lol_ie = c[0]; lol_rst_en = c[1];
      tick(1);
      chk("R5 irq routing", irq, c[0] & ~c[1]);
      chk("R7 rst_req routing", rst_req, c[1]);
    end
    lol_ie = 1; lol_rst_en = 0;
    tick(20);
    chk("R6 flag sticky", flags[0], 1);
    clear_flags(3'b001);
    chk("R6 cleared by w1c", flags[0], 0);
    chk("R7 irq drops", irq, 0);
    tick(20);
    chk("R4 single loss sets once", flags[0], 0);

    // R4 no flag while loop off
    write_mode(2'b00);
    lock = 1; tick(6); lock = 0; tick(6);
    chk("R4 no flag with loop off", flags[0], 0);
    write_mode(2'b01);

    // R8 reference out of range
    ref_max = 10; tick(WAITW);
    chk("R8 ref over max", flags[1], 1);
    chk("R7 ref irq", irq, 1);
    ref_max = 20; tick(WIN + 5);
    clear_flags(3'b010);
    tick(WAITW);
    chk("R8 ref back in range", flags[1], 0);
    ref_run = 0; tick(WAITW);
    chk("R8 stopped ref", flags[1], 1);
    ref_rst_en = 1; tick(1);
    chk("R7 ref reset route", rst_req, 1);
    chk("R7 ref irq masked", irq, 0);
    ref_run = 1; ref_rst_en = 0; tick(2 * WIN + 5);
    clear_flags(3'b010);
    tick(WAITW);
    chk("R8 ref restarted", flags[1], 0);

    // R9 synthesized judged only with lock
    syn_min = 90; tick(WAITW);
    chk("R9 not judged without lock", flags[2], 0);
    write_mode(2'b10);
    chk("R3 normal selects syn", sel_syn, 1);
    lock = 1; tick(WAITW);
    chk("R9 fault with lock", flags[2], 1);
    chk("R10 fallback sel", sel_syn, 0);
    chk("R10 mode kept", mode, 2);
    chk("R7 syn irq", irq, 1);
    syn_min = 74; tick(WIN + 5);
    clear_flags(3'b100);
    tick(WAITW);
    chk("R9 syn good", flags[2], 0);
    chk("R10 stays on reference", sel_syn, 0);
    write_mode(2'b10);
    chk("R11 reselect normal", sel_syn, 1);
    tick(WAITW);
    chk("R11 stays on syn", sel_syn, 1);

    // R10 reset route gives no fallback
    syn_rst_en = 1; syn_run = 0; tick(WAITW);
    chk("R10 syn flag", flags[2], 1);
    chk("R10 syn reset request", rst_req, 1);
    chk("R10 no fallback with reset route", sel_syn, 1);
    syn_run = 1; tick(2 * WIN + 5);
    clear_flags(3'b100);
    syn_rst_en = 0;
    tick(WAITW);
    chk("R9 syn recovered", flags[2], 0);

    // R12 exhaustive divider sweep
    for (int d = 0; d < 8; d++) begin
      write_div(d[DIV_W-1:0]);
      chk("R12 divider load", post_div, d);
      chk("R12 loop_pwr kept", loop_pwr, 1);
      chk("R12 sel kept", sel_syn, 1);
      tick(5);
      chk("R12 divider held", post_div, d);
      chk("R12 no lock loss", flags, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule